// File: doc/BRIEF.md
# Scanline Table DMA Engine

This block moves a short burst of bytes between a wide memory bus (24-bit address, called the A side) and a narrow register bus (8-bit address, called the B side) once per displayed scanline. Each of its channels walks a table in A-side memory. Each table entry starts with a line-count byte. Bit 7 of that byte asks for a transfer on every line of the run; with bit 7 clear, the burst happens only on the first line of the run. In indirect mode the count is followed by a 16-bit data pointer. A count byte of zero ends the channel's table for the frame.

The video timing logic pulses `line_start` with the scanline number, the visible height and an enable mask. The engine starts a frame at line 0 and services lines 1 through the visible height. Otherwise it finishes at once. It works through the channels in ascending order with one bus access per cycle. When the line is done it pulses `line_done` and holds the line's cycle cost on `line_cost`. Host software programs each channel through a byte-wide register port and can read every channel field back through the same port. Writes are accepted only while the engine is idle.

Top module: `hdma_engine`

## Requirements
- R1: Each channel has byte registers selected by `cfg_reg`: 0 control, 1 B target, 2/3 source address low/high, 4 source bank, 5/6 indirect pointer low/high, 7 indirect bank, 8/9 table address low/high, 10 line counter, 11 flags (bit 1 do-transfer, bit 0 completed, read-only). All reset to zero, and `cfg_rdata` returns the selected field combinationally.
- R2: Control bits [2:0] select the mode. Modes 0..7 move 1, 2, 2, 4, 4, 4, 2 and 4 bytes per burst.
- R3: Byte k of a burst goes to target plus an offset: k&1 in modes 1 and 5, (k>>1)&1 in modes 3 and 7, k in mode 4, and 0 otherwise.
- R4: At line 0 the completed flags of all channels are cleared and the do-transfer flag of every channel is set, enabled or not. Each enabled channel then copies its source address into its table address, zeroes its line counter and reloads.
- R5: A reload happens only when the counter's low 7 bits are zero. It reads the byte at {source bank, table address} into the counter and increments the table address. A zero byte sets completed and clears do-transfer. A nonzero byte clears completed and sets do-transfer.
- R6: In indirect mode (control bit 6) a reload then reads a little-endian pointer from the table. If the count byte was zero and no higher-numbered enabled channel is still uncompleted, only the low byte is read and the high byte becomes 0.
- R7: On lines 1..visible height, each enabled, uncompleted channel with do-transfer set moves its burst. The data comes from {source bank, table address} (direct) or {indirect bank, pointer} (indirect), and the address used is incremented after each byte.
- R8: After the bursts, each enabled, uncompleted channel decrements its counter, sets do-transfer to bit 7 of the new value and attempts a reload.
- R9: `line_cost` is 8 per serviced line, plus 8 per burst byte, plus 8 per table byte read. Within a line it grows only in steps of 0 or 8.
- R10: A line above the visible height, or any line with an all-zero enable mask, makes no bus access and finishes on the next cycle with cost 0.
- R11: Control bit 7 set moves data from the B side to the A side. Clear moves it from A to B.
- R12: `line_done` is a one-cycle pulse. Bus strobes appear only while `busy` is high, and the read and write strobes of one side are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe (idle only) |
| cfg_ch | input | CW | Channel select |
| cfg_reg | input | 4 | Register select |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Selected register value |
| en_mask | input | NCH | Channel enable mask |
| line_start | input | 1 | Start servicing a line |
| line_num | input | LINE_W | Current scanline |
| vis_height | input | LINE_W | Last visible scanline |
| busy | output | 1 | Engine working on a line |
| line_done | output | 1 | Line finished pulse |
| line_cost | output | COST_W | Cycle cost of the last line |
| a_addr | output | 24 | A-side address |
| a_rd | output | 1 | A-side read strobe |
| a_wr | output | 1 | A-side write strobe |
| a_wdata | output | 8 | A-side write data |
| a_rdata | input | 8 | A-side read data (same cycle) |
| b_addr | output | 8 | B-side address |
| b_rd | output | 1 | B-side read strobe |
| b_wr | output | 1 | B-side write strobe |
| b_wdata | output | 8 | B-side write data |
| b_rdata | input | 8 | B-side read data (same cycle) |

## Verification
The bench uses the default parameters: eight channels, a 9-bit line number and a 12-bit cost. With eight channels it can run the highest enabled channel next to a lower direct one, so both the shortened indirect reload and the full two-byte pointer read are exercised. It also checks that a disabled channel still receives do-transfer at frame start. The 9-bit line number lets lines above the visible height be driven, and the cost width holds the largest per-line total without wrap.

// File: rtl/hdma_pkg.sv
package hdma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_XFER, S_UPD, S_RL_CNT, S_RL_LO, S_RL_HI, S_DONE
  } hdma_state_t;

  typedef enum logic [1:0] {P_SETUP, P_XFER, P_UPD} hdma_phase_t;

  // index of the last byte of a burst for a mode
  function automatic logic [1:0] burst_last(input logic [2:0] mode);
    case (mode)
      3'd0:                      burst_last = 2'd0;
      3'd1, 3'd2, 3'd6:          burst_last = 2'd1;
      default:                   burst_last = 2'd3;
    endcase
  endfunction

  // B-side register offset of burst byte idx
  function automatic logic [7:0] b_bump(input logic [2:0] mode, input logic [1:0] idx);
    case (mode)
      3'd1, 3'd5: b_bump = {7'd0, idx[0]};
      3'd3, 3'd7: b_bump = {7'd0, idx[1]};
      3'd4:       b_bump = {6'd0, idx};
      default:    b_bump = 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/hdma_cfg_regs.sv
module hdma_cfg_regs #(
  parameter int NCH = 8,
  parameter int CW  = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] wch,
  input  logic [3:0]    wreg,
  input  logic [7:0]    wdata,
  output logic [7:0]    ctrl     [NCH],
  output logic [7:0]    target   [NCH],
  output logic [15:0]   src_addr [NCH],
  output logic [7:0]    src_bank [NCH],
  output logic [7:0]    ind_bank [NCH]
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wire hit = we && (wch == CW'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl[c] <= '0; target[c] <= '0; src_addr[c] <= '0;
        src_bank[c] <= '0; ind_bank[c] <= '0;
      end else if (hit) begin
        case (wreg)
          4'd0: ctrl[c]           <= wdata;
          4'd1: target[c]         <= wdata;
          4'd2: src_addr[c][7:0]  <= wdata;
          4'd3: src_addr[c][15:8] <= wdata;
          4'd4: src_bank[c]       <= wdata;
          4'd7: ind_bank[c]       <= wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hdma_tail_idle.sv
// fin[c]: no channel above c is both enabled and still uncompleted
module hdma_tail_idle #(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0] en,
  input  logic [NCH-1:0] comp,
  output logic [NCH-1:0] fin
);
  for (genvar c = 0; c < NCH; c++) begin : g_fin
    if (c == NCH - 1) begin : g_top
      assign fin[c] = 1'b1;
    end else begin : g_mid
      assign fin[c] = &(~en[NCH-1:c+1] | comp[NCH-1:c+1]);
    end
  end
endmodule

// File: rtl/hdma_engine.sv
module hdma_engine
  import hdma_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int LINE_W = 9,
  parameter int COST_W = 12,
  localparam int CW    = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CW-1:0]     cfg_ch,
  input  logic [3:0]        cfg_reg,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [NCH-1:0]    en_mask,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic [LINE_W-1:0] vis_height,
  output logic              busy,
  output logic              line_done,
  output logic [COST_W-1:0] line_cost,
  output logic [23:0]       a_addr,
  output logic              a_rd,
  output logic              a_wr,
  output logic [7:0]        a_wdata,
  input  logic [7:0]        a_rdata,
  output logic [7:0]        b_addr,
  output logic              b_rd,
  output logic              b_wr,
  output logic [7:0]        b_wdata,
  input  logic [7:0]        b_rdata
);
  localparam logic [COST_W-1:0] STEP = COST_W'(8);

  hdma_state_t state;
  hdma_phase_t phase;
  logic [CW-1:0]  ch;
  logic [1:0]     bi;
  logic [15:0]    tbl [NCH];
  logic [15:0]    ptr [NCH];
  logic [7:0]     lc  [NCH];
  logic [NCH-1:0] comp, dox, fin;

  logic [7:0]  ctrl [NCH], target [NCH], src_bank [NCH], ind_bank [NCH];
  logic [15:0] src_addr [NCH];

  wire idle = (state == S_IDLE);

  hdma_cfg_regs #(.NCH(NCH), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we && idle), .wch(cfg_ch),
    .wreg(cfg_reg), .wdata(cfg_wdata), .ctrl(ctrl), .target(target),
    .src_addr(src_addr), .src_bank(src_bank), .ind_bank(ind_bank)
  );

  hdma_tail_idle #(.NCH(NCH)) u_fin (.en(en_mask), .comp(comp), .fin(fin));

  // named events used by the checker and the datapath
  wire [2:0] mode      = ctrl[ch][2:0];
  wire       is_ind    = ctrl[ch][6];
  wire       dir_ba    = ctrl[ch][7];
  wire       ch_active = en_mask[ch] && !comp[ch];
  wire       xfer_go   = (state == S_XFER) && ch_active && dox[ch];
  wire       reload_go = (state == S_RL_CNT) && (lc[ch][6:0] == 7'd0);
  wire       table_rd  = reload_go || (state == S_RL_LO) || (state == S_RL_HI);
  wire       last_ch   = (ch == CW'(NCH - 1));
  wire       last_byte = (bi == burst_last(mode));
  wire [7:0] lc_dec    = lc[ch] - 8'd1;
  wire [23:0] tbl_ptr  = {src_bank[ch], tbl[ch]};

  hdma_state_t resume_st, adv_st;
  always_comb begin
    case (phase)
      P_SETUP: resume_st = S_SETUP;
      P_XFER:  resume_st = S_XFER;
      default: resume_st = S_UPD;
    endcase
    if (!last_ch)              adv_st = resume_st;
    else if (phase == P_XFER)  adv_st = S_UPD;
    else                       adv_st = S_DONE;
  end

  assign busy      = !idle;
  assign line_done = (state == S_DONE);
  assign a_addr    = table_rd ? tbl_ptr : (is_ind ? {ind_bank[ch], ptr[ch]} : tbl_ptr);
  assign a_rd      = table_rd || (xfer_go && !dir_ba);
  assign a_wr      = xfer_go && dir_ba;
  assign a_wdata   = b_rdata;
  assign b_addr    = target[ch] + b_bump(mode, bi);
  assign b_rd      = xfer_go && dir_ba;
  assign b_wr      = xfer_go && !dir_ba;
  assign b_wdata   = a_rdata;

  always_comb begin
    case (cfg_reg)
      4'd0:    cfg_rdata = ctrl[cfg_ch];
      4'd1:    cfg_rdata = target[cfg_ch];
      4'd2:    cfg_rdata = src_addr[cfg_ch][7:0];
      4'd3:    cfg_rdata = src_addr[cfg_ch][15:8];
      4'd4:    cfg_rdata = src_bank[cfg_ch];
      4'd5:    cfg_rdata = ptr[cfg_ch][7:0];
      4'd6:    cfg_rdata = ptr[cfg_ch][15:8];
      4'd7:    cfg_rdata = ind_bank[cfg_ch];
      4'd8:    cfg_rdata = tbl[cfg_ch][7:0];
      4'd9:    cfg_rdata = tbl[cfg_ch][15:8];
      4'd10:   cfg_rdata = lc[cfg_ch];
      4'd11:   cfg_rdata = {6'd0, dox[cfg_ch], comp[cfg_ch]};
      default: cfg_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; phase <= P_SETUP; ch <= '0; bi <= '0;
      line_cost <= '0; comp <= '0; dox <= '0;
      for (int i = 0; i < NCH; i++) begin
        tbl[i] <= '0; ptr[i] <= '0; lc[i] <= '0;
      end
    end else begin
      case (state)
        S_IDLE: begin
          if (cfg_we) begin
            case (cfg_reg)
              4'd5:  ptr[cfg_ch][7:0]  <= cfg_wdata;
              4'd6:  ptr[cfg_ch][15:8] <= cfg_wdata;
              4'd8:  tbl[cfg_ch][7:0]  <= cfg_wdata;
              4'd9:  tbl[cfg_ch][15:8] <= cfg_wdata;
              4'd10: lc[cfg_ch]        <= cfg_wdata;
              default: ;
            endcase
          end
          if (line_start) begin
            line_cost <= '0; ch <= '0; bi <= '0;
            if (line_num == '0) begin comp <= '0; dox <= '0; end
            if (en_mask == '0) state <= S_DONE;
            else if (line_num == '0) begin
              line_cost <= STEP; phase <= P_SETUP; state <= S_SETUP;
            end else if (line_num > vis_height) state <= S_DONE;
            else begin
              line_cost <= STEP; phase <= P_XFER; state <= S_XFER;
            end
          end
        end
        S_SETUP: begin
          dox[ch] <= 1'b1;
          if (en_mask[ch]) begin
            tbl[ch] <= src_addr[ch]; lc[ch] <= '0; state <= S_RL_CNT;
          end else begin
            state <= adv_st; ch <= last_ch ? '0 : ch + 1'b1;
          end
        end
        S_XFER: begin
          if (xfer_go) begin
            line_cost <= line_cost + STEP;
            if (is_ind) ptr[ch] <= ptr[ch] + 16'd1;
            else        tbl[ch] <= tbl[ch] + 16'd1;
          end
          if (xfer_go && !last_byte) bi <= bi + 2'd1;
          else begin
            bi <= '0; state <= adv_st; ch <= last_ch ? '0 : ch + 1'b1;
            if (last_ch) phase <= P_UPD;
          end
        end
        S_UPD: begin
          if (ch_active) begin
            lc[ch] <= lc_dec; dox[ch] <= lc_dec[7]; state <= S_RL_CNT;
          end else begin
            state <= adv_st; ch <= last_ch ? '0 : ch + 1'b1;
          end
        end
        S_RL_CNT: begin
          if (reload_go) begin
            lc[ch] <= a_rdata; tbl[ch] <= tbl[ch] + 16'd1;
            line_cost <= line_cost + STEP;
            comp[ch] <= (a_rdata == 8'd0); dox[ch] <= (a_rdata != 8'd0);
          end
          if (reload_go && is_ind) state <= S_RL_LO;
          else begin
            state <= adv_st; ch <= last_ch ? '0 : ch + 1'b1;
          end
        end
        S_RL_LO: begin
          ptr[ch][7:0] <= a_rdata; tbl[ch] <= tbl[ch] + 16'd1;
          line_cost <= line_cost + STEP;
          if (comp[ch] && fin[ch]) begin
            ptr[ch][15:8] <= 8'd0;
            state <= adv_st; ch <= last_ch ? '0 : ch + 1'b1;
          end else state <= S_RL_HI;
        end
        S_RL_HI: begin
          ptr[ch][15:8] <= a_rdata; tbl[ch] <= tbl[ch] + 16'd1;
          line_cost <= line_cost + STEP;
          state <= adv_st; ch <= last_ch ? '0 : ch + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hdma_checker.sv
module hdma_checker #(
  parameter int NCH    = 8,
  parameter int LINE_W = 9,
  parameter int COST_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              line_done,
  input logic              line_start,
  input logic [NCH-1:0]    en_mask,
  input logic [LINE_W-1:0] line_num,
  input logic [LINE_W-1:0] vis_height,
  input logic [COST_W-1:0] line_cost,
  input logic              a_rd,
  input logic              a_wr,
  input logic              b_rd,
  input logic              b_wr
);
  assert_a_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_rd && a_wr));
  assert_b_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_rd && b_wr));
  assert_bus_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd || a_wr || b_rd || b_wr) |-> busy);
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);
  assert_mask_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !busy && en_mask == '0) |=> (line_done && line_cost == '0));
  assert_past_vis_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !busy && line_num != '0 && line_num > vis_height)
      |=> (line_done && line_cost == '0));
  assert_cost_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |->
      (line_cost == $past(line_cost) || line_cost == $past(line_cost) + COST_W'(8)));
endmodule

bind hdma_engine hdma_checker #(.NCH(NCH), .LINE_W(LINE_W), .COST_W(COST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .line_done(line_done),
  .line_start(line_start), .en_mask(en_mask), .line_num(line_num),
  .vis_height(vis_height), .line_cost(line_cost), .a_rd(a_rd), .a_wr(a_wr),
  .b_rd(b_rd), .b_wr(b_wr)
);

// File: tb/test_hdma_engine.sv
`timescale 1ns/1ps
module test_hdma_engine;
  localparam int NCH = 8, LINE_W = 9, COST_W = 12, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              cfg_we = 1'b0;
  logic [CW-1:0]     cfg_ch = '0;
  logic [3:0]        cfg_reg = '0;
  logic [7:0]        cfg_wdata = '0, cfg_rdata;
  logic [NCH-1:0]    en_mask = '0;
  logic              line_start = 1'b0;
  logic [LINE_W-1:0] line_num = '0, vis_height = '0;
  logic              busy, line_done;
  logic [COST_W-1:0] line_cost;
  logic [23:0]       a_addr;
  logic              a_rd, a_wr, b_rd, b_wr;
  logic [7:0]        a_wdata, a_rdata, b_addr, b_wdata, b_rdata;

  logic [7:0] amem [4096];
  logic [7:0] breg [256];
  assign a_rdata = amem[a_addr[11:0]];
  assign b_rdata = breg[b_addr];
  always @(posedge clk) begin
    if (a_wr) amem[a_addr[11:0]] <= a_wdata;
    if (b_wr) breg[b_addr] <= b_wdata;
  end

  hdma_engine #(.NCH(NCH), .LINE_W(LINE_W), .COST_W(COST_W)) i_hdma_engine (.*);

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] expq [$];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every B-side write is matched against the queue
  always @(negedge clk) begin
    if (rst_n && b_wr) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected B write actual=%0h expected=none", {b_addr, b_wdata});
      end else begin
        logic [15:0] e;
        e = expq.pop_front();
        if (e != {b_addr, b_wdata}) begin
          errors++;
          $display("FAIL R3/R7 B write actual=%0h expected=%0h", {b_addr, b_wdata}, e);
        end
      end
    end
  end

  task automatic push_b(input logic [7:0] ad, input logic [7:0] d);
    expq.push_back({ad, d});
  endtask

  task automatic wr(input int c, input int r, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = CW'(c); cfg_reg = 4'(r); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input string tag, input int c, input int r, input int exp);
    @(negedge clk);
    cfg_ch = CW'(c); cfg_reg = 4'(r);
    #1 check(tag, int'(cfg_rdata), exp);
  endtask

  task automatic run_line(input string tag, input int ln, input int vh,
                          input logic [NCH-1:0] m, input int exp_cost);
    @(negedge clk);
    line_num = LINE_W'(ln); vis_height = LINE_W'(vh); en_mask = m; line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    while (!line_done) @(negedge clk);
    check(tag, int'(line_cost), exp_cost);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) amem[i] = 8'h00;
    for (int i = 0; i < 256; i++) breg[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_check("R1 reset ctrl", 0, 0, 0);
    rd_check("R1 reset flags", 0, 11, 0);

    // direct, mode 1, repeat entry then terminator
    amem[12'h100] = 8'h02; amem[12'h101] = 8'h11; amem[12'h102] = 8'h22;
    amem[12'h103] = 8'h81; amem[12'h104] = 8'h33; amem[12'h105] = 8'h44;
    amem[12'h106] = 8'h00;
    wr(0, 0, 8'h01); wr(0, 1, 8'h18); wr(0, 2, 8'h00); wr(0, 3, 8'h01); wr(0, 4, 8'h00);
    rd_check("R1 target readback", 0, 1, 8'h18);
    run_line("R4 R9 setup cost", 0, 10, 8'h01, 16);
    rd_check("R5 counter loaded", 0, 10, 8'h02);
    push_b(8'h18, 8'h11); push_b(8'h19, 8'h22);
    run_line("R7 R2 line1 cost", 1, 10, 8'h01, 24);
    run_line("R8 idle line cost", 2, 10, 8'h01, 16);
    push_b(8'h18, 8'h33); push_b(8'h19, 8'h44);
    run_line("R8 repeat line cost", 3, 10, 8'h01, 32);
    run_line("R5 completed line cost", 4, 10, 8'h01, 8);
    rd_check("R5 table addr low", 0, 8, 8'h07);
    rd_check("R5 table addr high", 0, 9, 8'h01);
    rd_check("R5 flags completed", 0, 11, 8'h01);
    rd_check("R5 counter zero", 0, 10, 8'h00);
    run_line("R10 past height", 20, 10, 8'h01, 0);
    run_line("R10 zero mask", 1, 10, 8'h00, 0);

    // ch1 direct mode 0, ch2 indirect mode 3 (top enabled channel)
    amem[12'h400] = 8'h01; amem[12'h401] = 8'h77; amem[12'h402] = 8'h00;
    amem[12'h200] = 8'h01; amem[12'h201] = 8'h00; amem[12'h202] = 8'h03;
    amem[12'h203] = 8'h00; amem[12'h204] = 8'h50; amem[12'h205] = 8'h66;
    amem[12'h300] = 8'hAA; amem[12'h301] = 8'hBB; amem[12'h302] = 8'hCC; amem[12'h303] = 8'hDD;
    wr(1, 0, 8'h00); wr(1, 1, 8'h30); wr(1, 2, 8'h00); wr(1, 3, 8'h04);
    wr(2, 0, 8'h43); wr(2, 1, 8'h20); wr(2, 2, 8'h00); wr(2, 3, 8'h02); wr(2, 7, 8'h00);
    run_line("R6 R9 setup two channels", 0, 10, 8'h06, 40);
    rd_check("R4 disabled ch do-transfer", 0, 11, 8'h02);
    rd_check("R6 full pointer low", 2, 5, 8'h00);
    rd_check("R6 full pointer high", 2, 6, 8'h03);
    push_b(8'h30, 8'h77);
    push_b(8'h20, 8'hAA); push_b(8'h20, 8'hBB); push_b(8'h21, 8'hCC); push_b(8'h21, 8'hDD);
    run_line("R7 R3 indirect line cost", 1, 10, 8'h06, 72);
    rd_check("R6 short pointer low", 2, 5, 8'h50);
    rd_check("R6 short pointer high", 2, 6, 8'h00);
    rd_check("R6 table after short reload", 2, 8, 8'h05);

    // ch3 B to A, mode 0
    breg[8'h40] = 8'h5A;
    amem[12'h500] = 8'h01; amem[12'h501] = 8'h00; amem[12'h502] = 8'h00;
    wr(3, 0, 8'h80); wr(3, 1, 8'h40); wr(3, 2, 8'h00); wr(3, 3, 8'h05);
    run_line("R11 setup cost", 0, 10, 8'h08, 16);
    run_line("R11 line cost", 1, 10, 8'h08, 24);
    @(negedge clk);
    check("R11 A written from B", int'(amem[12'h501]), 8'h5A);
    check("R7 no B writes left", expq.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule